// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block closes the digital half of a winding current loop. While the bridge is driving, a high-side permission flag stays up. When the analog sense comparator reports that the winding current has reached its trip level, that report first crosses into the clock domain through a two-flop synchroniser. The synchronised trip then drops the flag and starts an off period. The off period lasts a fixed number of oscillator cycles, 96 by default. The oscillator arrives as a one-clock strobe per oscillator cycle. When the off period ends, the flag rises again and a one-clock pulse asks the blanking timer to start.

During the off period the block tells the bridge decoder how the current should recirculate. A two-bit decay code is captured at the moment of the trip. It picks how much of the off period starts in fast decay, and the rest is spent in slow decay. The code can select all-slow, a short fast portion, a long fast portion or all-fast. Trips arriving while the blanking input is high are discarded. While enable is low, or while sleep or fault is high, the chopper sits idle with everything off. Leaving idle opens a fresh on period. All pins are plain level controls and strobes, so there is no stream interface and no back-pressure.

Top module: `chopper_top`

## Requirements
- R1: With the chopper in its on period and blanking inactive, a high level on `trip_raw` sampled at a clock edge drops `src_en` at the third rising edge from that one. The first two edges pass through the synchroniser.
- R2: An off period consumes exactly `OFF_TICKS` (96) `osc_tick` strobes. `src_en` rises at the edge that takes the last strobe.
- R3: Decay code 2'b00 keeps `slow_decay` high and `fast_decay` low for the whole off period.
- R4: Decay code 2'b01 gives `fast_decay` for the first 14 strobes of the off period and 2'b10 gives it for the first 46. `slow_decay` holds for the remaining strobes.
- R5: Decay code 2'b11 keeps `fast_decay` high and `slow_decay` low for the whole off period.
- R6: A trip seen while `blank_active` is high, or during an off period, has no effect on `src_en` or on the length of the off period.
- R7: `blank_start` is a one-clock pulse, issued in exactly the cycles where `src_en` has just risen: at the end of an off period and on leaving idle.
- R8: While `enable` is low or `sleep` or `fault` is high, `src_en`, `fast_decay` and `slow_decay` are low one edge later and stay low. The off count is discarded. The first edge with all three idle conditions clear raises `src_en`.
- R9: The decay code is captured with the trip. Changing `decay_sel` during an off period does not change that period's split.
- R10: During and straight after reset, all four outputs are low.
- R11: `fast_decay` and `slow_decay` are never high together, and neither is high while `src_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-clock strobe per oscillator cycle |
| trip_raw | input | 1 | Unsynchronised sense comparator output, high at trip |
| blank_active | input | 1 | High while the blanking timer masks the comparator |
| decay_sel | input | 2 | Decay split code: 00 slow, 01 short fast, 10 long fast, 11 fast |
| enable | input | 1 | High to allow driving |
| sleep | input | 1 | High forces idle |
| fault | input | 1 | High forces idle |
| src_en | output | 1 | High-side permission flag |
| fast_decay | output | 1 | Fast recirculation request during the off period |
| slow_decay | output | 1 | Slow recirculation request during the off period |
| blank_start | output | 1 | One-clock request to restart blanking |

## Verification
The hardest case to reach is a change of decay code or a forced idle in the middle of an off period, because either one must land after the synchronised trip has been taken and before the 96th strobe. The stimulus waits at the ports for `src_en` to fall and then rewrites `decay_sel`, or raises a fault, a fixed number of cycles later. A behavioural model checks every cycle, so any split that followed the new code, or any count that survived the idle, shows up as a mismatch. The fast and total strobe counts are also measured directly for each code and for two strobe rates.

// File: rtl/chopper_pkg.sv
package chopper_pkg;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_ON   = 2'd1,
    CH_OFF  = 2'd2
  } chop_state_t;

  // Number of strobes spent in fast decay for a given split code.
  function automatic int unsigned fast_span(input logic [1:0] code,
                                            input int unsigned short_n,
                                            input int unsigned long_n,
                                            input int unsigned total_n);
    case (code)
      2'b00:   return 0;
      2'b01:   return short_n;
      2'b10:   return long_n;
      default: return total_n;
    endcase
  endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/chop_offcnt.sv
module chop_offcnt #(
  parameter int TICKS = 96,
  parameter int CW    = $clog2(TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic          last
);
  localparam logic [CW-1:0] LAST_VAL = CW'(TICKS - 1);

  assign last = run && tick && (cnt == LAST_VAL);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (last)  cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  // R2: the count never passes the last off-time strobe
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(TICKS));

  // R2: without a strobe the running count holds
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));
endmodule

// File: rtl/chop_decay.sv
module chop_decay
  import chopper_pkg::*;
#(
  parameter int TICKS   = 96,
  parameter int SHORT_N = 14,
  parameter int LONG_N  = 46,
  parameter int CW      = $clog2(TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [1:0]    sel_in,
  input  logic          off,
  input  logic [CW-1:0] cnt,
  output logic          fast,
  output logic          slow
);
  logic [1:0]    sel_q;
  logic [CW-1:0] fast_n;

  always_ff @(posedge clk) begin
    if (!rst_n)       sel_q <= 2'b00;
    else if (capture) sel_q <= sel_in;
  end

  assign fast_n = CW'(fast_span(sel_q, SHORT_N, LONG_N, TICKS));
  assign fast   = off && (cnt < fast_n);
  assign slow   = off && !fast;

  // R9: the captured code stays put across an off period
  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (off && $past(off)) |-> $stable(sel_q));
endmodule

// File: rtl/chopper_top.sv
module chopper_top
  import chopper_pkg::*;
#(
  parameter int OFF_TICKS   = 96,
  parameter int FAST_SHORT  = 14,
  parameter int FAST_LONG   = 46,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       trip_raw,
  input  logic       blank_active,
  input  logic [1:0] decay_sel,
  input  logic       enable,
  input  logic       sleep,
  input  logic       fault,
  output logic       src_en,
  output logic       fast_decay,
  output logic       slow_decay,
  output logic       blank_start
);
  localparam int CW = $clog2(OFF_TICKS + 1);

  chop_state_t   st;
  logic          trip_s;
  logic          idle;
  logic          take_trip;
  logic          cnt_last;
  logic          bs_q;
  logic [CW-1:0] off_cnt;

  assign idle      = !enable || sleep || fault;
  assign take_trip = (st == CH_ON) && trip_s && !blank_active && !idle;

  chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (trip_raw),
    .q_sync  (trip_s)
  );

  chop_offcnt #(.TICKS(OFF_TICKS), .CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   ((st == CH_OFF) && !idle),
    .tick  (osc_tick),
    .cnt   (off_cnt),
    .last  (cnt_last)
  );

  chop_decay #(.TICKS(OFF_TICKS), .SHORT_N(FAST_SHORT),
               .LONG_N(FAST_LONG), .CW(CW)) u_decay (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (take_trip),
    .sel_in  (decay_sel),
    .off     (st == CH_OFF),
    .cnt     (off_cnt),
    .fast    (fast_decay),
    .slow    (slow_decay)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= CH_IDLE;
      bs_q <= 1'b0;
    end else begin
      bs_q <= 1'b0;
      if (idle) begin
        st <= CH_IDLE;
      end else begin
        case (st)
          CH_IDLE: begin
            st   <= CH_ON;
            bs_q <= 1'b1;
          end
          CH_ON: if (take_trip) st <= CH_OFF;
          CH_OFF: if (cnt_last) begin
            st   <= CH_ON;
            bs_q <= 1'b1;
          end
          default: st <= CH_IDLE;
        endcase
      end
    end
  end

  assign src_en      = (st == CH_ON);
  assign blank_start = bs_q;

  // R1: an accepted synchronised trip ends the on period
  p_trip_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en && trip_s && !blank_active && !idle) |=> !src_en);

  // R6: blanking keeps the on period alive
  p_blank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en && blank_active && !idle) |=> src_en);

  // R8: idle conditions clear all drive requests
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (!src_en && !fast_decay && !slow_decay));

  // R7: blanking restart coincides with each rise of src_en
  p_bs_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_en) |-> blank_start);
  p_bs_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blank_start |-> $rose(src_en));

  // R11: decay requests are exclusive and absent during the on period
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    src_en |-> (!fast_decay && !slow_decay));
  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fast_decay, slow_decay}));
endmodule

// File: tb/chopper_top_test.sv
`timescale 1ns/1ps
module chopper_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       trip_raw = 1'b0;
  logic       blank_active = 1'b0;
  logic [1:0] decay_sel = 2'b00;
  logic       enable = 1'b0;
  logic       sleep = 1'b0;
  logic       fault = 1'b0;
  logic       src_en, fast_decay, slow_decay, blank_start;

  int checks = 0;
  int errors = 0;
  int tick_div = 3;
  int tick_phase = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chopper_top uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .trip_raw(trip_raw),
    .blank_active(blank_active), .decay_sel(decay_sel), .enable(enable),
    .sleep(sleep), .fault(fault), .src_en(src_en), .fast_decay(fast_decay),
    .slow_decay(slow_decay), .blank_start(blank_start)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // oscillator strobe generator
  always @(negedge clk) begin
    if (tick_phase >= tick_div - 1) begin
      osc_tick   <= 1'b1;
      tick_phase <= 0;
    end else begin
      osc_tick   <= 1'b0;
      tick_phase <= tick_phase + 1;
    end
  end

  // behavioural reference model
  int m_mode;          // 0 idle, 1 on, 2 off
  int m_left;          // strobes still to go in the off period
  int m_fast_left;     // strobes still in fast decay
  bit m_bs;
  bit m_hist[$];       // trip_raw history, newest at back

  function automatic int fast_len(input logic [1:0] c);
    if (c == 2'b00) return 0;
    if (c == 2'b01) return 14;
    if (c == 2'b10) return 46;
    return 96;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_fast_left = 0; m_bs = 0;
      m_hist = {};
      m_hist.push_back(1'b0);
      m_hist.push_back(1'b0);
    end else begin
      bit seen;
      seen = m_hist[0];
      m_bs = 0;
      if (!enable || sleep || fault) begin
        m_mode = 0;
      end else if (m_mode == 0) begin
        m_mode = 1; m_bs = 1;
      end else if (m_mode == 1) begin
        if (seen && !blank_active) begin
          m_mode = 2; m_left = 96; m_fast_left = fast_len(decay_sel);
        end
      end else if (osc_tick) begin
        m_left--;
        if (m_fast_left > 0) m_fast_left--;
        if (m_left == 0) begin m_mode = 1; m_bs = 1; end
      end
      void'(m_hist.pop_front());
      m_hist.push_back(trip_raw);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1", "src_en vs model", src_en, m_mode == 1);
      check("R4", "fast_decay vs model", fast_decay, (m_mode == 2) && (m_fast_left > 0));
      check("R3", "slow_decay vs model", slow_decay, (m_mode == 2) && (m_fast_left == 0));
      check("R7", "blank_start vs model", blank_start, m_bs);
    end
  end

  task automatic pulse_trip();
    @(negedge clk); trip_raw = 1'b1;
    @(negedge clk); trip_raw = 1'b0;
  endtask

  // Trip, then count total and fast strobes over the off period.
  task automatic measure(input logic [1:0] code, input logic [1:0] late_code,
                         input int exp_fast, input string req);
    int ticks, fticks, guard;
    @(negedge clk); decay_sel = code;
    pulse_trip();
    guard = 0;
    while (src_en && guard < 10) begin @(negedge clk); guard++; end
    check("R1", "src_en fell after trip", src_en, 0);
    decay_sel = late_code;
    ticks = 0; fticks = 0; guard = 0;
    #1;
    while (!src_en && guard < 2000) begin
      if (fast_decay && slow_decay) check("R11", "both decay requests", 1, 0);
      if (osc_tick) begin
        ticks++;
        if (fast_decay) fticks++;
      end
      @(negedge clk); #1;
      guard++;
    end
    check("R2", "strobes in off period", ticks, 96);
    check(req, "fast strobes", fticks, exp_fast);
    check("R7", "blank_start at off end", blank_start, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "src_en in reset", src_en, 0);
    check("R10", "fast_decay in reset", fast_decay, 0);
    check("R10", "slow_decay in reset", slow_decay, 0);
    check("R10", "blank_start in reset", blank_start, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "src_en after reset while disabled", src_en, 0);
    enable = 1'b1;
    @(negedge clk);
    check("R8", "src_en on leaving idle", src_en, 1);
    check("R7", "blank_start on leaving idle", blank_start, 1);
    repeat (3) @(negedge clk);

    measure(2'b00, 2'b00, 0,  "R3");
    measure(2'b01, 2'b01, 14, "R4");
    measure(2'b10, 2'b10, 46, "R4");
    measure(2'b11, 2'b11, 96, "R5");
    // R9: code rewritten after the trip is taken
    measure(2'b01, 2'b11, 14, "R9");
    measure(2'b11, 2'b00, 96, "R9");
    tick_div = 1;
    repeat (2) @(negedge clk);
    measure(2'b10, 2'b10, 46, "R4");
    tick_div = 4;
    repeat (5) @(negedge clk);

    // R6: trip while blanking is active
    blank_active = 1'b1;
    pulse_trip();
    repeat (4) @(negedge clk);
    check("R6", "src_en held under blanking", src_en, 1);
    blank_active = 1'b0;
    repeat (3) @(negedge clk);

    // R6: extra trips during an off period do not stretch it
    @(negedge clk); decay_sel = 2'b00;
    pulse_trip();
    repeat (20) begin
      @(negedge clk); trip_raw = ~trip_raw;
    end
    trip_raw = 1'b0;
    begin
      int guard = 0;
      while (!src_en && guard < 2000) begin @(negedge clk); guard++; end
      // off started 3 edges after the pulse, strobe every 4 clocks
      check("R6", "off period length in clocks unaffected", (guard + 21 > 380) && (guard + 21 < 395), 1);
    end
    repeat (3) @(negedge clk);

    // R8: fault in the middle of an off period
    pulse_trip();
    repeat (30) @(negedge clk);
    fault = 1'b1;
    @(negedge clk);
    check("R8", "src_en low under fault", src_en, 0);
    check("R8", "decay low under fault", fast_decay | slow_decay, 0);
    pulse_trip();
    repeat (5) @(negedge clk);
    check("R8", "src_en stays low under fault", src_en, 0);
    fault = 1'b0;
    @(negedge clk);
    check("R8", "src_en back after fault", src_en, 1);
    check("R7", "blank_start after fault", blank_start, 1);
    repeat (3) @(negedge clk);

    // R8: sleep and enable low
    sleep = 1'b1;
    @(negedge clk);
    check("R8", "src_en low in sleep", src_en, 0);
    sleep = 1'b0; enable = 1'b0;
    @(negedge clk);
    check("R8", "src_en low while disabled", src_en, 0);
    enable = 1'b1;
    @(negedge clk);
    check("R8", "src_en after enable", src_en, 1);
    // fresh off period after idle is a full one
    measure(2'b01, 2'b01, 14, "R4");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    checks++;
    errors++;
    $display("FAIL watchdog run did not complete");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule